// File: doc/BRIEF.md
# Divided Clock Phase-Select Generator

This block turns a fast source clock into a card-interface clock at one quarter of the source frequency. It also makes two delayed copies of that base clock. The drive copy times the launch of command and data toward a card. The sample copy times their capture. Each copy is delayed by a programmable multiple of 45 degrees of the base period. One 45-degree step is half a source period, so the block captures on both source edges to reach that step.

The two phase codes are separate static configuration inputs. A source-select bit can replace the shifted sample copy with an external alternative clock. Configuration is meant to be set while the block is held in reset, or left unchanged while the clocks run. Reset is asynchronous and active-low, and its release is synchronised to the source clock. All outputs are low while reset is applied and start low after it.

Top module: `clk_phase_gen`

## Requirements
- R1: `base_clk` has a period of exactly four `src_clk` periods. It is high for two source periods and low for two.
- R2: While `rst_n` is low, `base_clk`, `drv_clk` and `smp_clk` (with `smp_src_sel` = 0) are all low, from the moment reset is applied.
- R3: With 3-bit `drv_phase` = c, every rising edge of `drv_clk` comes c × half a source period after a rising edge of `base_clk`, counted modulo four source periods. Code 0 is aligned with `base_clk`. Odd codes land on falling source edges.
- R4: With `smp_src_sel` = 0 and 3-bit `smp_phase` = c, `smp_clk` rises c × half a source period after `base_clk`, counted modulo four source periods.
- R5: For every code, `drv_clk` and the shifted `smp_clk` have a period of four source periods and are high for exactly two.
- R6: `smp_src_sel` = 1 makes `smp_clk` equal `alt_smp_clk` combinationally. `smp_src_sel` = 0 selects the phase-shifted copy.
- R7: The drive and sample phase settings are independent. Each output follows only its own code, even when the two codes differ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Fast source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| drv_phase | input | 3 | Drive clock phase code, shift = code × 45 degrees |
| smp_phase | input | 3 | Sample clock phase code, shift = code × 45 degrees |
| smp_src_sel | input | 1 | 0: shifted sample copy, 1: alternative clock |
| alt_smp_clk | input | 1 | Alternative sample clock source |
| base_clk | output | 1 | Source clock divided by four |
| drv_clk | output | 1 | Phase-shifted drive clock |
| smp_clk | output | 1 | Sample clock |

## Verification
The bench walks all eight codes on both shifters, using a different code on each. For each code it measures the rising-edge offset from the base clock, the period and the high time. Swapping the rising and falling tap paths, or indexing the tap line off by one, shows up as a wrong offset for odd or even codes. A base counter that decodes the wrong count gives a skewed duty cycle or a wrong period. The bench also applies reset in the middle of a period, expecting every output to drop at once, and toggles the alternative sample source to confirm the select bit bypasses the shifter.

// File: rtl/clk_phase_pkg.sv
package clk_phase_pkg;
  // Phase code width; the divide ratio is 2**(PHASE_W-1) and steps are half a source cycle
  localparam int DEF_PHASE_W     = 3;
  localparam int DEF_SYNC_STAGES = 2;
  // Number of independent phase shifters (drive, sample)
  localparam int NUM_SHIFTERS    = 2;
  localparam int SHIFT_DRV       = 0;
  localparam int SHIFT_SMP       = 1;

  typedef enum logic {
    SMP_SRC_SHIFTED = 1'b0,
    SMP_SRC_ALT     = 1'b1
  } smp_src_e;
endpackage

// File: rtl/cpg_rst_sync.sv
module cpg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/cpg_base_div.sv
module cpg_base_div #(
  parameter int CNT_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic base
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             base_q, base_d;

  // High for the first half of the count range, low for the second half
  always_comb begin
    cnt_d  = cnt_q;
    base_d = base_q;
    if (en) begin
      cnt_d  = cnt_q + 1'b1;
      base_d = ~cnt_q[CNT_W-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      base_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      base_q <= base_d;
    end
  end

  assign base = base_q;
endmodule

// File: rtl/cpg_delay_line.sv
module cpg_delay_line #(
  parameter int TAPS = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            din,
  output logic [TAPS-1:0] rise_taps,
  output logic [TAPS-1:0] fall_taps
);
  // Rising-edge chain: tap k lags din by k source cycles
  logic [TAPS-1:1] chain_q, chain_d;

  assign rise_taps = {chain_q, din};

  always_comb begin
    chain_d = chain_q;
    if (en) chain_d = rise_taps[TAPS-2:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  // Falling-edge copies: each adds half a source cycle to its rising tap
  for (genvar k = 0; k < TAPS; k++) begin : g_fall
    logic half_q, half_d;
    always_comb begin
      half_d = half_q;
      if (en) half_d = rise_taps[k];
    end
    always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) half_q <= 1'b0;
      else        half_q <= half_d;
    end
    assign fall_taps[k] = half_q;
  end
endmodule

// File: rtl/cpg_phase_sel.sv
module cpg_phase_sel #(
  parameter int PHASE_W = 3,
  localparam int TAPS   = 1 << (PHASE_W - 1)
) (
  input  logic [TAPS-1:0]    rise_taps,
  input  logic [TAPS-1:0]    fall_taps,
  input  logic [PHASE_W-1:0] code,
  output logic               clk_out
);
  logic [PHASE_W-2:0] tap_idx;

  always_comb begin
    tap_idx = code[PHASE_W-1:1];
    clk_out = code[0] ? fall_taps[tap_idx] : rise_taps[tap_idx];
  end
endmodule

// File: rtl/clk_phase_gen.sv
module clk_phase_gen
  import clk_phase_pkg::*;
#(
  parameter int PHASE_W     = DEF_PHASE_W,
  parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic               src_clk,
  input  logic               rst_n,
  input  logic [PHASE_W-1:0] drv_phase,
  input  logic [PHASE_W-1:0] smp_phase,
  input  logic               smp_src_sel,
  input  logic               alt_smp_clk,
  output logic               base_clk,
  output logic               drv_clk,
  output logic               smp_clk
);
  localparam int CNT_W = PHASE_W - 1;
  localparam int TAPS  = 1 << CNT_W;

  logic            rst_n_int;
  logic            run_en;
  logic            base_int;
  logic [TAPS-1:0] rise_taps;
  logic [TAPS-1:0] fall_taps;
  logic [PHASE_W-1:0] code_arr [NUM_SHIFTERS];
  logic [NUM_SHIFTERS-1:0] shift_out;
  smp_src_e        smp_src;

  cpg_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (src_clk),
    .arst_n     (rst_n),
    .rst_n_sync (rst_n_int)
  );

  assign run_en = rst_n_int;

  cpg_base_div #(.CNT_W(CNT_W)) u_base_div (
    .clk   (src_clk),
    .rst_n (rst_n_int),
    .en    (run_en),
    .base  (base_int)
  );

  cpg_delay_line #(.TAPS(TAPS)) u_delay_line (
    .clk       (src_clk),
    .rst_n     (rst_n_int),
    .en        (run_en),
    .din       (base_int),
    .rise_taps (rise_taps),
    .fall_taps (fall_taps)
  );

  assign code_arr[SHIFT_DRV] = drv_phase;
  assign code_arr[SHIFT_SMP] = smp_phase;

  for (genvar g = 0; g < NUM_SHIFTERS; g++) begin : g_shift
    cpg_phase_sel #(.PHASE_W(PHASE_W)) u_sel (
      .rise_taps (rise_taps),
      .fall_taps (fall_taps),
      .code      (code_arr[g]),
      .clk_out   (shift_out[g])
    );
  end

  assign smp_src  = smp_src_e'(smp_src_sel);
  assign base_clk = base_int;
  assign drv_clk  = shift_out[SHIFT_DRV];
  assign smp_clk  = (smp_src == SMP_SRC_ALT) ? alt_smp_clk : shift_out[SHIFT_SMP];
endmodule

// File: rtl/clk_phase_gen_chk.sv
module clk_phase_gen_chk #(
  parameter int PHASE_W = 3
) (
  input logic               src_clk,
  input logic               rst_n,
  input logic [PHASE_W-1:0] drv_phase,
  input logic [PHASE_W-1:0] smp_phase,
  input logic               smp_src_sel,
  input logic               alt_smp_clk,
  input logic               base_clk,
  input logic               drv_clk,
  input logic               smp_clk
);
  AST_BASE_HIGH_TWO: assert property (@(posedge src_clk) disable iff (!rst_n)
    $rose(base_clk) |=> ##1 $fell(base_clk)); // R1
  AST_BASE_LOW_TWO: assert property (@(posedge src_clk) disable iff (!rst_n)
    $fell(base_clk) |=> ##1 $rose(base_clk)); // R1

  always @(posedge src_clk) begin
    if (!rst_n) begin
      AST_RESET_LOW: assert (!base_clk && !drv_clk) else $error("outputs not low in reset"); // R2
    end
  end

  AST_DRV_EVEN_STEP: assert property (@(posedge src_clk) disable iff (!rst_n)
    (drv_phase == PHASE_W'(2)) |-> (drv_clk == $past(base_clk))); // R3
  AST_DRV_ODD_STEP: assert property (@(negedge src_clk) disable iff (!rst_n)
    (drv_phase == PHASE_W'(1)) |=> (drv_clk == $past(base_clk))); // R3
  AST_SMP_ALIGNED: assert property (@(posedge src_clk) disable iff (!rst_n)
    (!smp_src_sel && smp_phase == '0) |-> (smp_clk == base_clk)); // R4
  AST_SMP_ALT_PASS: assert property (@(posedge src_clk) disable iff (!rst_n)
    smp_src_sel |-> (smp_clk == alt_smp_clk)); // R6
endmodule

bind clk_phase_gen clk_phase_gen_chk #(.PHASE_W(PHASE_W)) u_chk (
  .src_clk     (src_clk),
  .rst_n       (rst_n),
  .drv_phase   (drv_phase),
  .smp_phase   (smp_phase),
  .smp_src_sel (smp_src_sel),
  .alt_smp_clk (alt_smp_clk),
  .base_clk    (base_clk),
  .drv_clk     (drv_clk),
  .smp_clk     (smp_clk)
);

// File: tb/clk_phase_gen_test.sv
`timescale 1ns/1ps
module clk_phase_gen_test;
  localparam real HALF = 2.5;
  localparam real PER  = 5.0;
  localparam real BASE_PER = 4.0 * PER;

  logic src_clk;
  logic rst_n;
  logic [2:0] drv_phase, smp_phase;
  logic smp_src_sel, alt_smp_clk;
  logic base_clk, drv_clk, smp_clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  clk_phase_gen uut (
    .src_clk(src_clk), .rst_n(rst_n), .drv_phase(drv_phase), .smp_phase(smp_phase),
    .smp_src_sel(smp_src_sel), .alt_smp_clk(alt_smp_clk),
    .base_clk(base_clk), .drv_clk(drv_clk), .smp_clk(smp_clk)
  );

  initial src_clk = 1'b0;
  always #(HALF) src_clk = ~src_clk;

  // Edge time stamps
  real b_rise, b_prev;
  real d_rise, d_prev, d_fall;
  real s_rise, s_prev, s_fall;
  always @(posedge base_clk) begin b_prev = b_rise; b_rise = $realtime; end
  always @(posedge drv_clk)  begin d_prev = d_rise; d_rise = $realtime; end
  always @(negedge drv_clk)  d_fall = $realtime;
  always @(posedge smp_clk)  begin s_prev = s_rise; s_rise = $realtime; end
  always @(negedge smp_clk)  s_fall = $realtime;

  function automatic real wrapm(real x);
    return x - BASE_PER * $floor(x / BASE_PER);
  endfunction

  task automatic check(string req, string what, real act, real exp);
    checks++;
    if (act > exp + 0.01 || act < exp - 0.01) begin
      fails++;
      $display("FAIL %s %s actual=%0.3f expected=%0.3f", req, what, act, exp);
    end
  endtask

  // Scoreboard
  typedef struct { string req; string what; real val; } exp_t;
  exp_t exp_q[$];
  event meas_ev;

  task automatic push_exp(string req, string what, real val);
    exp_t e;
    e.req = req; e.what = what; e.val = val;
    exp_q.push_back(e);
  endtask

  // Driver: expected items for the current codes, computed from the requirements
  task automatic drive_codes(int dc, int sc);
    rst_n = 1'b0;
    @(negedge src_clk);
    drv_phase = 3'(dc); smp_phase = 3'(sc); smp_src_sel = 1'b0;
    repeat (3) @(negedge src_clk);
    rst_n = 1'b1;
    repeat (24) @(negedge src_clk);
    push_exp("R1", "base period", BASE_PER);
    push_exp("R3", $sformatf("drv offset code %0d", dc), wrapm(dc * HALF));
    push_exp("R5", "drv period", BASE_PER);
    push_exp("R5", "drv high time", 2.0 * PER);
    push_exp("R4", $sformatf("smp offset code %0d", sc), wrapm(sc * HALF));
    push_exp("R5", "smp period", BASE_PER);
    push_exp("R5", "smp high time", 2.0 * PER);
    -> meas_ev;
    wait (exp_q.size() == 0);
  endtask

  // Monitor: measures and compares in push order
  always @(meas_ev) begin
    real meas [7];
    meas[0] = b_rise - b_prev;
    meas[1] = wrapm(d_rise - b_rise);
    meas[2] = d_rise - d_prev;
    meas[3] = wrapm(d_fall - d_rise);
    meas[4] = wrapm(s_rise - b_rise);
    meas[5] = s_rise - s_prev;
    meas[6] = wrapm(s_fall - s_rise);
    for (int i = 0; i < 7; i++) begin
      exp_t e;
      e = exp_q.pop_front();
      check(e.req, e.what, meas[i], e.val);
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000.0 * PER);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; drv_phase = 3'd0; smp_phase = 3'd0;
    smp_src_sel = 1'b0; alt_smp_clk = 1'b0;
    repeat (3) @(negedge src_clk);
    // R2: reset state
    check("R2", "base_clk in reset", real'(base_clk), 0.0);
    check("R2", "drv_clk in reset",  real'(drv_clk),  0.0);
    check("R2", "smp_clk in reset",  real'(smp_clk),  0.0);

    // R3 R4 R5 R7: every code, drive and sample codes differ
    for (int c = 0; c < 8; c++) drive_codes(c, 7 - c);
    drive_codes(5, 2); // R7 extra independent pair

    // R2: reset applied mid-period drops every output at once
    drive_codes(3, 6);
    @(posedge base_clk);
    #(PER + 1.0);
    rst_n = 1'b0;
    #0.5;
    check("R2", "base_clk after async reset", real'(base_clk), 0.0);
    check("R2", "drv_clk after async reset",  real'(drv_clk),  0.0);
    check("R2", "smp_clk after async reset",  real'(smp_clk),  0.0);

    // R6: alternative sample source passes through
    drive_codes(0, 0);
    smp_src_sel = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge src_clk);
      alt_smp_clk = ((i * 5 + 1) % 3) == 0;
      #1.0;
      check("R6", "smp_clk follows alt", real'(smp_clk), real'(alt_smp_clk));
    end
    smp_src_sel = 1'b0;
    #0.5;
    check("R6", "smp_clk back to shifted copy", real'(smp_clk), real'(base_clk));

    repeat (4) @(negedge src_clk);
    finish_run();
  end
endmodule